// File: doc/BRIEF.md
# Bus Target Address-Phase Decoder

This block sits on the target side of a parallel, clock-synchronous shared bus and decides whether the device should respond to a transaction. It samples a 32-bit address and a 4-bit command code in the cycle in which the address phase is presented. It sorts the command into a memory, I/O or configuration class, or into no class at all. It compares the address against one programmable memory window and one programmable I/O window, and it takes account of a per-slot configuration select line.

Addresses above 4 GiB use a two-cycle address phase. A special command code in the first cycle carries the low 32 address bits. The following cycle carries the high 32 bits and the real command. One clock after the address phase has been fully sampled, the block issues a one-cycle claim pulse together with the transfer direction and a normalised command class.

After a claim, the block turns the active-low byte enables of each data cycle into an active-high write mask, and it flags data cycles in which no byte is enabled.

Top module: `bus_target_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `claim`, `claim_wr`, `claim_dac`, `claim_cls`, `wr_mask` and `be_nop` are all zero.
- R2: A claim appears as a single-cycle pulse on `claim`, registered one clock after the cycle that completes the address phase. `claim_wr`, `claim_cls` and `claim_dac` are valid in the same cycle and are zero when there is no claim.
- R3: For a claimed command, `claim_wr` equals bit 0 of the command (1 = write, 0 = read). `claim_cls` is encoded as 1 = memory, 2 = I/O, 3 = configuration; 0 means no claim.
- R4: Codes 0000, 0001 (broadcast), 0100, 0101, 1000 and 1001 are never claimed.
- R5: Memory codes 0110, 0111, 1100, 1110 and 1111 are claimed when the address falls inside the memory window. 1100 and 1110 are reported as memory reads, and 1111 as a memory write.
- R6: A window matches when the address equals the base in every bit at or above position `size_log2`. The effective memory size is never below 16 bytes (log2 = 4), and the effective I/O size is never below 4 bytes (log2 = 2).
- R7: I/O codes 0010 and 0011 are claimed when the 32-bit address falls inside the I/O window.
- R8: Configuration codes 1010 and 1011 are claimed only when `cfg_sel` is high in the sampled cycle, whatever the address.
- R9: Code 1101 makes the block keep the low address and use the next cycle's `ad` as address bits 63:32, together with that cycle's command. The claim comes one clock after the second cycle, with `claim_dac` = 1. A single-cycle phase compares with address bits 63:32 equal to zero. No claim is issued in the cycle between the two halves.
- R10: If `phase_vld` is low in the cycle after a 1101, or that cycle again carries 1101, the block returns to idle without claiming.
- R11: I/O and configuration commands that arrive through a two-cycle address phase are not claimed.
- R12: With `ADDR64_EN` = 0, code 1101 is ignored and the cycle after it is not taken as an address phase, so nothing is claimed for either cycle.
- R13: From the cycle after a write claim until the next address phase, `wr_mask` equals the inverted `be_n` of the previous cycle. `wr_mask` is zero for read claims and for unclaimed transactions.
- R14: During a claimed transaction (read or write), `be_nop` is high one clock after a cycle in which every `be_n` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_vld | input | 1 | Address-phase cycle marker |
| ad | input | 32 | Address bus (low or high half) |
| cmd | input | 4 | Command code |
| be_n | input | 4 | Active-low byte enables of the data cycle |
| cfg_sel | input | 1 | Per-slot configuration select |
| mem_base | input | 64 | Memory window base |
| mem_size_log2 | input | 7 | Memory window size, log2 bytes |
| io_base | input | 32 | I/O window base |
| io_size_log2 | input | 6 | I/O window size, log2 bytes |
| claim | output | 1 | Claim pulse |
| claim_wr | output | 1 | Direction of the claimed transaction |
| claim_cls | output | 2 | Class of the claimed transaction |
| claim_dac | output | 1 | The claim came from a two-cycle address phase |
| wr_mask | output | 4 | Active-high byte write mask |
| be_nop | output | 1 | No byte enabled in the data cycle |

## Verification
The bench runs all sixteen command codes against a memory hit, an I/O hit and a miss, each with and without the configuration select. A decoder that took reserved or broadcast codes, or that ignored the select line, would claim where it must stay silent. The two-cycle address phase is tested with upper bits that only match when both halves are combined. It is also tested with an abandoned second cycle, a repeated 1101 and a 32-bit-only instance. A design that mishandled any of these would claim early, claim from the wrong address, or treat the high half as a fresh address phase. Window edges at the 16-byte and 4-byte minimum sizes, and byte masks under writes, reads and unclaimed phases, catch an off-by-one size clamp and a mask that leaks outside claimed writes.

// File: rtl/tgt_dec_pkg.sv
package tgt_dec_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_IO   = 2'd2,
    CLS_CFG  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_SKIP = 2'd2
  } dec_st_e;

  localparam logic [CMD_W-1:0] OP_IO_RD   = 4'b0010;
  localparam logic [CMD_W-1:0] OP_IO_WR   = 4'b0011;
  localparam logic [CMD_W-1:0] OP_MEM_RD  = 4'b0110;
  localparam logic [CMD_W-1:0] OP_MEM_WR  = 4'b0111;
  localparam logic [CMD_W-1:0] OP_CFG_RD  = 4'b1010;
  localparam logic [CMD_W-1:0] OP_CFG_WR  = 4'b1011;
  localparam logic [CMD_W-1:0] OP_MEM_RDM = 4'b1100;
  localparam logic [CMD_W-1:0] OP_WIDE    = 4'b1101;
  localparam logic [CMD_W-1:0] OP_MEM_RDL = 4'b1110;
  localparam logic [CMD_W-1:0] OP_MEM_WRI = 4'b1111;
endpackage

// File: rtl/tgt_cmd_class.sv
module tgt_cmd_class import tgt_dec_pkg::*; (
  input  logic [CMD_W-1:0] cmd,
  output cls_e             cls,
  output logic             wr,
  output logic             wide
);
  always_comb begin
    unique case (cmd)
      OP_IO_RD, OP_IO_WR:                      cls = CLS_IO;
      OP_MEM_RD, OP_MEM_WR, OP_MEM_RDM,
      OP_MEM_RDL, OP_MEM_WRI:                  cls = CLS_MEM;
      OP_CFG_RD, OP_CFG_WR:                    cls = CLS_CFG;
      default:                                 cls = CLS_NONE;
    endcase
  end

  assign wr   = (cls != CLS_NONE) && cmd[0];
  assign wide = (cmd == OP_WIDE);
endmodule

// File: rtl/tgt_win_match.sv
module tgt_win_match #(
  parameter int AW       = 64,
  parameter int MIN_LOG2 = 4,
  parameter int SW       = $clog2(AW) + 1
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size_log2,
  output logic          hit
);
  localparam logic [SW-1:0] MIN_SZ = SW'(MIN_LOG2);

  logic [SW-1:0] eff_sz;
  logic [AW-1:0] diff;

  assign eff_sz = (size_log2 < MIN_SZ) ? MIN_SZ : size_log2;

  for (genvar g = 0; g < AW; g++) begin : g_bit
    assign diff[g] = (addr[g] ^ base[g]) & (SW'(g) >= eff_sz);
  end

  assign hit = ~|diff;
endmodule

// File: rtl/tgt_be_track.sv
module tgt_be_track #(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            new_phase,
  input  logic            claim_set,
  input  logic            claim_set_wr,
  input  logic [BE_W-1:0] be_n,
  output logic [BE_W-1:0] wr_mask,
  output logic            be_nop
);
  logic open_q;
  logic open_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      open_wr_q <= 1'b0;
      wr_mask   <= '0;
      be_nop    <= 1'b0;
    end else begin
      if (claim_set) begin
        open_q    <= 1'b1;
        open_wr_q <= claim_set_wr;
      end else if (new_phase) begin
        open_q    <= 1'b0;
        open_wr_q <= 1'b0;
      end
      wr_mask <= (open_q && open_wr_q) ? ~be_n : '0;
      be_nop  <= open_q && (&be_n);
    end
  end
endmodule

// File: rtl/bus_target_decoder.sv
module bus_target_decoder import tgt_dec_pkg::*; #(
  parameter int AD_W         = 32,
  parameter int BE_W         = AD_W / 8,
  parameter bit ADDR64_EN    = 1'b1,
  parameter int MEM_MIN_LOG2 = 4,
  parameter int IO_MIN_LOG2  = 2,
  parameter int MSZ_W        = $clog2(2 * AD_W) + 1,
  parameter int ISZ_W        = $clog2(AD_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_vld,
  input  logic [AD_W-1:0]   ad,
  input  logic [3:0]        cmd,
  input  logic [BE_W-1:0]   be_n,
  input  logic              cfg_sel,
  input  logic [2*AD_W-1:0] mem_base,
  input  logic [MSZ_W-1:0]  mem_size_log2,
  input  logic [AD_W-1:0]   io_base,
  input  logic [ISZ_W-1:0]  io_size_log2,
  output logic              claim,
  output logic              claim_wr,
  output logic [1:0]        claim_cls,
  output logic              claim_dac,
  output logic [BE_W-1:0]   wr_mask,
  output logic              be_nop
);
  localparam int MA_W = 2 * AD_W;

  dec_st_e          state_q, state_nxt;
  logic [AD_W-1:0]  lo_q;
  cls_e             cls;
  logic             cmd_wr, cmd_wide;
  logic             use_hi, sample, claim_nxt;
  logic [MA_W-1:0]  mem_addr;
  logic             mem_hit, io_hit;
  cls_e             cls_q;

  tgt_cmd_class u_class (
    .cmd  (cmd),
    .cls  (cls),
    .wr   (cmd_wr),
    .wide (cmd_wide)
  );

  assign use_hi   = (state_q == ST_HIGH);
  assign mem_addr = use_hi ? {ad, lo_q} : {{AD_W{1'b0}}, ad};

  tgt_win_match #(.AW(MA_W), .MIN_LOG2(MEM_MIN_LOG2), .SW(MSZ_W)) u_mem_win (
    .addr      (mem_addr),
    .base      (mem_base),
    .size_log2 (mem_size_log2),
    .hit       (mem_hit)
  );

  tgt_win_match #(.AW(AD_W), .MIN_LOG2(IO_MIN_LOG2), .SW(ISZ_W)) u_io_win (
    .addr      (ad),
    .base      (io_base),
    .size_log2 (io_size_log2),
    .hit       (io_hit)
  );

  assign sample = phase_vld && (state_q == ST_IDLE || state_q == ST_HIGH);

  always_comb begin
    claim_nxt = 1'b0;
    if (sample && !cmd_wide) begin
      unique case (cls)
        CLS_MEM: claim_nxt = mem_hit;
        CLS_IO:  claim_nxt = io_hit && !use_hi;
        CLS_CFG: claim_nxt = cfg_sel && !use_hi;
        default: claim_nxt = 1'b0;
      endcase
    end
  end

  always_comb begin
    state_nxt = ST_IDLE;
    if (state_q == ST_IDLE && phase_vld && cmd_wide)
      state_nxt = ADDR64_EN ? ST_HIGH : ST_SKIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      lo_q      <= '0;
      claim     <= 1'b0;
      claim_wr  <= 1'b0;
      cls_q     <= CLS_NONE;
      claim_dac <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (state_q == ST_IDLE && phase_vld && cmd_wide)
        lo_q <= ad;
      claim     <= claim_nxt;
      claim_wr  <= claim_nxt && cmd_wr;
      cls_q     <= claim_nxt ? cls : CLS_NONE;
      claim_dac <= claim_nxt && use_hi;
    end
  end

  assign claim_cls = cls_q;

  tgt_be_track #(.BE_W(BE_W)) u_be (
    .clk          (clk),
    .rst          (rst),
    .new_phase    (phase_vld && state_q == ST_IDLE),
    .claim_set    (claim_nxt),
    .claim_set_wr (cmd_wr),
    .be_n         (be_n),
    .wr_mask      (wr_mask),
    .be_nop       (be_nop)
  );

  // R2: a claim is always preceded by a sampled address-phase cycle
  a_r2_claim_after_phase: assert property (@(posedge clk) disable iff (rst)
    claim |-> $past(phase_vld));

  // R3: claimed transactions carry a class and the command's direction bit
  a_r3_claim_has_class: assert property (@(posedge clk) disable iff (rst)
    claim |-> (claim_cls != CLS_NONE) && (claim_wr == $past(cmd[0])));

  // R4: reserved and broadcast codes never lead to a claim
  a_r4_no_reserved: assert property (@(posedge clk) disable iff (rst)
    claim |-> !($past(cmd) inside {4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001}));

  // R8: configuration claims need the select line in the sampled cycle
  a_r8_cfg_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (claim && claim_cls == CLS_CFG) |-> $past(cfg_sel));

  // R9: a wide claim follows two consecutive address-phase cycles
  a_r9_wide_two_cycles: assert property (@(posedge clk) disable iff (rst)
    claim_dac |-> ($past(phase_vld) && $past(phase_vld, 2)));

  // R11: wide phases never claim I/O or configuration space
  a_r11_wide_mem_only: assert property (@(posedge clk) disable iff (rst)
    claim_dac |-> (claim_cls == CLS_MEM));

  // R13: the write mask never enables a byte whose enable was inactive
  a_r13_mask_within_enables: assert property (@(posedge clk) disable iff (rst)
    (wr_mask & $past(be_n)) == '0);
endmodule

// File: tb/bus_target_decoder_tb.sv
module bus_target_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_vld = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cmd = '0;
  logic [3:0]  be_n = 4'hF;
  logic        cfg_sel = 1'b0;
  logic [63:0] mem_base = 64'h0000_0000_8000_0000;
  logic [6:0]  mem_size_log2 = 7'd12;
  logic [31:0] io_base = 32'h0000_1000;
  logic [5:0]  io_size_log2 = 6'd4;

  logic       claim, claim_wr, claim_dac, be_nop;
  logic [1:0] claim_cls;
  logic [3:0] wr_mask;
  logic       claim32, claim_wr32, claim_dac32, be_nop32;
  logic [1:0] claim_cls32;
  logic [3:0] wr_mask32;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_target_decoder u_dut (
    .clk(clk), .rst(rst), .phase_vld(phase_vld), .ad(ad), .cmd(cmd), .be_n(be_n),
    .cfg_sel(cfg_sel), .mem_base(mem_base), .mem_size_log2(mem_size_log2),
    .io_base(io_base), .io_size_log2(io_size_log2), .claim(claim), .claim_wr(claim_wr),
    .claim_cls(claim_cls), .claim_dac(claim_dac), .wr_mask(wr_mask), .be_nop(be_nop)
  );

  bus_target_decoder #(.ADDR64_EN(1'b0)) u_dut32 (
    .clk(clk), .rst(rst), .phase_vld(phase_vld), .ad(ad), .cmd(cmd), .be_n(be_n),
    .cfg_sel(cfg_sel), .mem_base(mem_base), .mem_size_log2(mem_size_log2),
    .io_base(io_base), .io_size_log2(io_size_log2), .claim(claim32), .claim_wr(claim_wr32),
    .claim_cls(claim_cls32), .claim_dac(claim_dac32), .wr_mask(wr_mask32), .be_nop(be_nop32)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [63:0] a, input logic [63:0] b,
                                  input int sz, input int mn);
    int e = (sz < mn) ? mn : sz;
    return (e >= 64) ? 1'b1 : ((a >> e) == (b >> e));
  endfunction

  // expected {claim, wr, cls} from the requirements
  function automatic logic [3:0] expect_dec(input logic [3:0] c, input logic [31:0] hi,
                                            input logic [31:0] lo, input logic s, input logic wide);
    logic hit;
    logic [1:0] k;
    hit = 1'b0;
    k   = 2'd0;
    if (c inside {4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111}) begin
      k = 2'd1; hit = in_win({hi, lo}, mem_base, int'(mem_size_log2), 4);
    end else if (c inside {4'b0010, 4'b0011}) begin
      k = 2'd2; hit = !wide && (hi == 0) && in_win({32'h0, lo}, {32'h0, io_base}, int'(io_size_log2), 2);
    end else if (c inside {4'b1010, 4'b1011}) begin
      k = 2'd3; hit = !wide && s;
    end
    return hit ? {1'b1, c[0], k} : 4'b0000;
  endfunction

  task automatic do_phase(input logic [3:0] c, input logic [31:0] a, input logic s);
    @(negedge clk);
    phase_vld = 1'b1; cmd = c; ad = a; cfg_sel = s;
    @(negedge clk);
    phase_vld = 1'b0; cmd = '0; ad = '0; cfg_sel = 1'b0;
  endtask

  task automatic do_wide(input logic [31:0] lo, input logic second, input logic [3:0] c,
                         input logic [31:0] hi, output logic mid, output logic mid32);
    @(negedge clk);
    phase_vld = 1'b1; cmd = 4'b1101; ad = lo;
    @(negedge clk);
    mid = claim; mid32 = claim32;
    phase_vld = second; cmd = second ? c : 4'h0; ad = second ? hi : 32'h0;
    @(negedge clk);
    phase_vld = 1'b0; cmd = '0; ad = '0;
  endtask

  task automatic t_reset();
    chk("R1 claim in reset", claim, 0);
    chk("R1 mask in reset", {wr_mask, be_nop, claim_wr, claim_cls, claim_dac}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {claim, claim_wr, claim_cls, claim_dac, wr_mask, be_nop}, 0);
  endtask

  task automatic t_sweep();
    logic [31:0] addrs [3];
    addrs[0] = 32'h8000_0040; addrs[1] = 32'h0000_1002; addrs[2] = 32'h4000_0000;
    for (int c = 0; c < 16; c++) begin
      if (c == 13) continue;
      for (int ai = 0; ai < 3; ai++) begin
        for (int s = 0; s < 2; s++) begin
          logic [3:0] e;
          e = expect_dec(4'(c), 32'h0, addrs[ai], s[0], 1'b0);
          do_phase(4'(c), addrs[ai], s[0]);
          // R2 R3 R4 R5 R7 R8: claim, direction and class for every code
          chk($sformatf("R3 R4 R5 R7 R8 code %0d addr %0d sel %0d", c, ai, s),
              {claim, claim_wr, claim_cls}, e);
          chk("R2 dac flag on single phase", claim_dac, 0);
          @(negedge clk);
          chk("R2 claim is one cycle", claim, 0);
        end
      end
    end
  endtask

  task automatic t_window();
    mem_size_log2 = 7'd2;
    do_phase(4'b0110, 32'h8000_000C, 1'b0);
    chk("R6 memory minimum 16 bytes, top byte", claim, 1);
    do_phase(4'b0110, 32'h8000_0010, 1'b0);
    chk("R6 memory minimum 16 bytes, next byte", claim, 0);
    mem_size_log2 = 7'd12;
    do_phase(4'b0111, 32'h8000_0FFF, 1'b0);
    chk("R6 memory 4 KiB top", claim, 1);
    do_phase(4'b0111, 32'h8000_1000, 1'b0);
    chk("R6 memory 4 KiB beyond", claim, 0);
    io_size_log2 = 6'd0;
    do_phase(4'b0010, 32'h0000_1003, 1'b0);
    chk("R6 io minimum 4 bytes, top byte", claim, 1);
    do_phase(4'b0010, 32'h0000_1004, 1'b0);
    chk("R6 io minimum 4 bytes, next byte", claim, 0);
    io_size_log2 = 6'd4;
  endtask

  task automatic t_wide();
    logic m, m32;
    mem_base = 64'h0000_0002_8000_0000;
    do_phase(4'b0110, 32'h8000_0040, 1'b0);
    chk("R9 single phase implies zero upper half", claim, 0);
    do_wide(32'h8000_0040, 1'b1, 4'b0110, 32'h0000_0002, m, m32);
    chk("R9 no claim between halves", m, 0);
    chk("R9 wide memory read claim", {claim, claim_wr, claim_cls, claim_dac}, 5'b1_0_01_1);
    do_wide(32'h8000_0040, 1'b1, 4'b1111, 32'h0000_0002, m, m32);
    chk("R9 R5 wide invalidate-write as memory write", {claim, claim_wr, claim_cls}, 4'b1_1_01);
    do_wide(32'h8000_0040, 1'b1, 4'b0110, 32'h0000_0003, m, m32);
    chk("R9 wide upper half miss", claim, 0);
    do_wide(32'h8000_0040, 1'b0, 4'b0110, 32'h0000_0002, m, m32);
    chk("R10 abandoned second cycle", {m, claim}, 0);
    do_wide(32'h8000_0040, 1'b1, 4'b1101, 32'h0000_0002, m, m32);
    chk("R10 repeated wide code", claim, 0);
    do_phase(4'b0110, 32'h0000_0000, 1'b0);
    chk("R10 back to idle, miss", claim, 0);
    do_wide(32'h0000_1002, 1'b1, 4'b0011, 32'h0000_0000, m, m32);
    chk("R11 wide I/O not claimed", claim, 0);
    cfg_sel = 1'b1;
    do_wide(32'h0000_0000, 1'b1, 4'b1010, 32'h0000_0000, m, m32);
    chk("R11 wide configuration not claimed", claim, 0);
    cfg_sel = 1'b0;
    mem_base = 64'h0000_0000_8000_0000;
    do_wide(32'h0000_0000, 1'b1, 4'b0110, 32'h8000_0040, m, m32);
    chk("R12 32-bit target ignores wide code", m32, 0);
    chk("R12 32-bit target skips high half", claim32, 0);
    do_phase(4'b0110, 32'h8000_0040, 1'b0);
    chk("R12 32-bit target claims next normal phase", {claim32, claim_cls32}, 3'b1_01);
  endtask

  task automatic t_bytes();
    do_phase(4'b0111, 32'h8000_0040, 1'b0);
    chk("R13 write claimed", claim, 1);
    be_n = 4'b1010;
    @(negedge clk);
    chk("R13 write mask inverted enables", wr_mask, 4'b0101);
    be_n = 4'b1111;
    @(negedge clk);
    chk("R14 no-op on write", {wr_mask, be_nop}, 5'b0000_1);
    be_n = 4'b0000;
    @(negedge clk);
    chk("R13 full write mask", {wr_mask, be_nop}, 5'b1111_0);
    do_phase(4'b0110, 32'h8000_0040, 1'b0);
    be_n = 4'b0000;
    @(negedge clk);
    chk("R13 read claim gives no mask", {wr_mask, be_nop}, 0);
    be_n = 4'b1111;
    @(negedge clk);
    chk("R14 no-op on read", be_nop, 1);
    do_phase(4'b0111, 32'h4000_0000, 1'b0);
    be_n = 4'b0000;
    @(negedge clk);
    chk("R13 unclaimed write gives no mask", wr_mask, 0);
    be_n = 4'b1111;
    @(negedge clk);
    chk("R14 unclaimed transaction has no no-op flag", be_nop, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_sweep();
    t_window();
    t_wide();
    t_bytes();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule